// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer

This block computes the next program counter for a core that runs hardware loops and subroutine calls. The core presents the address of the instruction it is executing, a decoded control operation with its target, offset, loop-count and loop-end fields, and a condition-true bit. The block answers in the same cycle with the address to fetch next. Its state changes on the following clock edge.

Two last-in-first-out stores hold the control state. The return stack holds subroutine return addresses and loop-end addresses, and a tag bit on each entry tells which kind it is. The counter stack holds, for each open loop, the remaining iteration count and the address of the first body instruction. When the executing address equals a loop-end entry on top of the return stack, the block sends the PC back to the body start, or falls through when the count is exhausted. This costs no cycles and needs no branch instruction. The surrounding core registers `next_pc_o` as its program counter. The core must not place a control operation at a loop-end address. Nested loops must end at distinct addresses.

Top module: `zol_sequencer`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), both stacks are empty, `lce_o`, `ovf_err_o` and `unf_err_o` are 0, and a no-op (op code 0) gives `next_pc_o` = `pc_i`+1.
- R2: Op code 1 (absolute jump) gives `target_i`, and op code 2 (relative jump) gives `pc_i` plus the sign-extended `offset_i`, when `cond_i` is 1. When `cond_i` is 0 the result is `pc_i`+1.
- R3: Op codes 3 and 4 (absolute and relative call) with `cond_i`=1 branch like op codes 1 and 2 and push `pc_i`+1. Op code 5 (return) with `cond_i`=1 pops the top entry into `next_pc_o`.
- R4: Op code 6 (loop start) gives `pc_i`+1. It pushes `loop_end_i` onto the return stack and pushes `count_i` and `pc_i`+1 onto the counter stack. At the loop end with a count above 1, `next_pc_o` is the loop-start address plus 1 and the count drops by one. A count of N runs the body N times.
- R5: `lce_o` is 1 exactly when a loop is open and its count is 1 or less. At the loop end in that state, both stacks pop and `next_pc_o` is `pc_i`+1.
- R6: A loop with count 1 runs its body once, and a count of 0 behaves like 1.
- R7: Loops nest and may contain calls. An inner loop completes all its iterations on every pass of the outer loop, and a return inside a loop goes back to the caller.
- R8: A call made while the return stack holds 30 entries sets the sticky `ovf_err_o` and still branches, but pushes nothing.
- R9: A loop start made when the counter stack holds 6 entries, or when the return stack is full, sets `ovf_err_o` and pushes onto neither stack.
- R10: A return with an empty return stack sets the sticky `unf_err_o` and gives `pc_i`+1. The error flags stay at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_i | input | 24 | Address of the executing instruction |
| op_i | input | 3 | Control op code (0 none, 1 jump abs, 2 jump rel, 3 call abs, 4 call rel, 5 return, 6 loop start) |
| cond_i | input | 1 | Condition true for jumps, calls and returns |
| target_i | input | 24 | Absolute branch target |
| offset_i | input | 16 | Signed relative branch offset |
| count_i | input | 32 | Iteration count for loop start |
| loop_end_i | input | 24 | Address of the last body instruction |
| next_pc_o | output | 24 | Address to fetch next |
| lce_o | output | 1 | Top loop count is expired (1 or less) |
| ovf_err_o | output | 1 | Sticky push-when-full error |
| unf_err_o | output | 1 | Sticky pop-when-empty error |

## Verification
If a return-stack entry is lost, or a tag bit is wrong, the fault shows up when execution reaches the matching loop end or return. At that point the block either misses the branch back or jumps to an address from another nest level. A count that drifts shows as one iteration too many or too few, and `lce_o` rises on the wrong pass. A stack depth that is off by one shows only at the 30th or 6th push, or at the final pop, so the bench fills both stacks to their limits and empties them again. Every result is compared on the cycle it is produced, so any fault appears within one cycle of the first place the PC stream goes wrong.

// File: rtl/zol_pkg.sv
// Shared definitions for the loop sequencer: control op codes.
package zol_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_NONE     = 3'd0,
        OP_JMP_ABS  = 3'd1,
        OP_JMP_REL  = 3'd2,
        OP_CALL_ABS = 3'd3,
        OP_CALL_REL = 3'd4,
        OP_RET      = 3'd5,
        OP_LOOP     = 3'd6
    } ctl_op_e;
endpackage

// File: rtl/zol_lifo.sv
// Register-based last-in-first-out store.
// The store can push, pop, or rewrite its top entry in a cycle; it never
// does more than one of these at once.
// Assumes: the owner never pushes when full_o is 1, and never pops or
// rewrites when empty_o is 1. The owner guards these cases and raises errors.
module zol_lifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic         repl_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] top_o,
    output logic         full_o,
    output logic         empty_o
);
    localparam int PW  = $clog2(DEPTH + 1);
    localparam int AIW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] ptr;

    assign full_o  = (ptr == PW'(DEPTH));
    assign empty_o = (ptr == '0);
    assign top_o   = empty_o ? '0 : mem[AIW'(ptr - 1'b1)];

    // Occupancy count: up on push, down on pop.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr <= '0;
        else if (push_i) ptr <= ptr + 1'b1;
        else if (pop_i)  ptr <= ptr - 1'b1;
    end

    // Entry storage: write the new entry, or rewrite the top one.
    always_ff @(posedge clk) begin
        if (push_i)      mem[AIW'(ptr)]        <= data_i;
        else if (repl_i) mem[AIW'(ptr - 1'b1)] <= data_i;
    end

    a_r8_push_has_room: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);
    a_r10_pop_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i || repl_i) |-> !empty_o);
    a_r9_one_op: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({push_i, pop_i, repl_i}) <= 1);
    a_r8_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= PW'(DEPTH));
endmodule

// File: rtl/zol_target_gen.sv
// Computes the fall-through address and the PC-relative branch address.
// Assumes: OW < AW. The offset is two's complement and wraps in AW bits.
module zol_target_gen #(
    parameter int AW = 24,
    parameter int OW = 16
) (
    input  logic [AW-1:0] pc_i,
    input  logic [OW-1:0] offset_i,
    output logic [AW-1:0] pc_inc_o,
    output logic [AW-1:0] pc_rel_o
);
    localparam int XW = AW - OW;

    logic [AW-1:0] ofs_ext;

    // Sign-extend the offset and form both candidate addresses.
    always_comb begin
        ofs_ext  = {{XW{offset_i[OW-1]}}, offset_i};
        pc_inc_o = pc_i + 1'b1;
        pc_rel_o = pc_i + ofs_ext;
    end
endmodule

// File: rtl/zol_sequencer.sv
// Next-PC sequencer with a tagged return stack and a loop-counter stack.
// Tag 1 on a return-stack entry marks a loop end; tag 0 marks a return address.
// A loop end on top of the return stack takes priority over op_i.
// Assumes: the core registers next_pc_o as its PC, puts no control op at a
// loop-end address, and gives nested loops distinct end addresses.
module zol_sequencer
    import zol_pkg::*;
#(
    parameter int AW       = 24,
    parameter int CW       = 32,
    parameter int OW       = 16,
    parameter int PC_DEPTH = 30,
    parameter int LC_DEPTH = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   pc_i,
    input  logic [OP_W-1:0] op_i,
    input  logic            cond_i,
    input  logic [AW-1:0]   target_i,
    input  logic [OW-1:0]   offset_i,
    input  logic [CW-1:0]   count_i,
    input  logic [AW-1:0]   loop_end_i,
    output logic [AW-1:0]   next_pc_o,
    output logic            lce_o,
    output logic            ovf_err_o,
    output logic            unf_err_o
);
    localparam int PSW = AW + 1;
    localparam int LSW = CW + AW;

    logic [AW-1:0]  pc_inc, pc_rel;
    logic [PSW-1:0] ps_top, ps_din;
    logic [LSW-1:0] ls_top, ls_din;
    logic ps_push, ps_pop, ps_full, ps_empty;
    logic ls_push, ls_pop, ls_repl, ls_full, ls_empty;
    logic ovf_set, unf_set, at_end, expired, loop_on;
    logic [AW-1:0] top_addr, loop_start;
    logic [CW-1:0] loop_cnt;
    ctl_op_e op;

    zol_target_gen #(.AW(AW), .OW(OW)) u_tgt (
        .pc_i(pc_i), .offset_i(offset_i), .pc_inc_o(pc_inc), .pc_rel_o(pc_rel)
    );

    zol_lifo #(.W(PSW), .DEPTH(PC_DEPTH)) u_ret_stack (
        .clk(clk), .rst_n(rst_n), .push_i(ps_push), .pop_i(ps_pop),
        .repl_i(1'b0), .data_i(ps_din), .top_o(ps_top),
        .full_o(ps_full), .empty_o(ps_empty)
    );

    zol_lifo #(.W(LSW), .DEPTH(LC_DEPTH)) u_cnt_stack (
        .clk(clk), .rst_n(rst_n), .push_i(ls_push), .pop_i(ls_pop),
        .repl_i(ls_repl), .data_i(ls_din), .top_o(ls_top),
        .full_o(ls_full), .empty_o(ls_empty)
    );

    // Decode the stack tops and detect the loop-end address.
    always_comb begin
        op         = ctl_op_e'(op_i);
        top_addr   = ps_top[AW-1:0];
        loop_cnt   = ls_top[LSW-1:AW];
        loop_start = ls_top[AW-1:0];
        loop_on    = !ls_empty;
        expired    = loop_on && (loop_cnt < CW'(2));
        at_end     = loop_on && !ps_empty && ps_top[AW] && (pc_i == top_addr);
    end

    assign lce_o = expired;

    // Choose the next PC and the stack operations for this cycle.
    always_comb begin
        next_pc_o = pc_inc;
        ps_push = 1'b0; ps_pop = 1'b0; ps_din = '0;
        ls_push = 1'b0; ls_pop = 1'b0; ls_repl = 1'b0; ls_din = '0;
        ovf_set = 1'b0; unf_set = 1'b0;
        if (at_end) begin
            if (expired) begin
                ps_pop = 1'b1;
                ls_pop = 1'b1;
            end else begin
                ls_repl   = 1'b1;
                ls_din    = {loop_cnt - 1'b1, loop_start};
                next_pc_o = loop_start;
            end
        end else begin
            case (op)
                OP_JMP_ABS: if (cond_i) next_pc_o = target_i;
                OP_JMP_REL: if (cond_i) next_pc_o = pc_rel;
                OP_CALL_ABS, OP_CALL_REL: if (cond_i) begin
                    next_pc_o = (op == OP_CALL_ABS) ? target_i : pc_rel;
                    if (ps_full) ovf_set = 1'b1;
                    else begin
                        ps_push = 1'b1;
                        ps_din  = {1'b0, pc_inc};
                    end
                end
                OP_RET: if (cond_i) begin
                    if (ps_empty) unf_set = 1'b1;
                    else begin
                        ps_pop    = 1'b1;
                        next_pc_o = top_addr;
                    end
                end
                OP_LOOP: begin
                    if (ps_full || ls_full) ovf_set = 1'b1;
                    else begin
                        ps_push = 1'b1;
                        ps_din  = {1'b1, loop_end_i};
                        ls_push = 1'b1;
                        ls_din  = {count_i, pc_inc};
                    end
                end
                default: ;
            endcase
        end
    end

    // Sticky error flags, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_err_o <= 1'b0;
            unf_err_o <= 1'b0;
        end else begin
            ovf_err_o <= ovf_err_o | ovf_set;
            unf_err_o <= unf_err_o | unf_set;
        end
    end

    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err_o |=> ovf_err_o);
    a_r10_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        unf_err_o |=> unf_err_o);
    a_r4_count_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
        (at_end && !expired) |=> (loop_cnt == CW'($past(loop_cnt) - 1'b1)));
    a_r9_loop_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!at_end && op_i == 3'd6 && ls_full) |=> ovf_err_o);
    a_r5_expired_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (at_end && expired) |-> (next_pc_o == pc_i + 1'b1));
endmodule

// File: tb/tb_zol_sequencer.sv
// Scoreboard bench. The driver computes the expected outputs from a
// requirement-level model and queues them; the monitor compares the DUT.
module tb_zol_sequencer;
    import zol_pkg::*;

    localparam int AW = 24, CW = 32, OW = 16, PD = 30, LD = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [AW-1:0] pc_i = '0, target_i = '0, loop_end_i = '0;
    logic [2:0]    op_i = '0;
    logic          cond_i = 1'b0;
    logic [OW-1:0] offset_i = '0;
    logic [CW-1:0] count_i = '0;
    logic [AW-1:0] next_pc_o;
    logic lce_o, ovf_err_o, unf_err_o;

    always #5 clk = ~clk;

    zol_sequencer dut (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .op_i(op_i), .cond_i(cond_i),
        .target_i(target_i), .offset_i(offset_i), .count_i(count_i),
        .loop_end_i(loop_end_i), .next_pc_o(next_pc_o), .lce_o(lce_o),
        .ovf_err_o(ovf_err_o), .unf_err_o(unf_err_o)
    );

    int n_cmp = 0, n_bad = 0;
    logic [AW+2:0] exp_q[$];
    string         tag_q[$];
    event          chk_ev;

    // model state
    logic [AW-1:0] pc;
    logic [AW-1:0] m_paddr [PD];
    logic          m_ptag  [PD];
    logic [CW-1:0] m_cnt   [LD];
    logic [AW-1:0] m_start [LD];
    int m_psp, m_csp;
    logic m_ovf, m_unf;

    // program store for loop runs
    logic [2:0]    p_op  [64];
    logic [AW-1:0] p_tgt [64];
    logic [CW-1:0] p_cnt [64];
    logic [AW-1:0] p_end [64];

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
    end

    // monitor: pop one expected item per trigger and compare
    initial begin
        forever begin
            @(chk_ev);
            #1;
            begin
                logic [AW+2:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if ({next_pc_o, lce_o, ovf_err_o, unf_err_o} !== e) begin
                    n_bad++;
                    $display("FAIL %s pc=%h: actual next=%h lce=%b ovf=%b unf=%b expected next=%h lce=%b ovf=%b unf=%b",
                             t, pc_i, next_pc_o, lce_o, ovf_err_o, unf_err_o,
                             e[AW+2:3], e[2], e[1], e[0]);
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        op_i = 3'd0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_psp = 0; m_csp = 0; m_ovf = 1'b0; m_unf = 1'b0;
    endtask

    // one cycle: drive, predict, queue, update model
    task automatic step(input logic [2:0] op, input logic cond,
                        input logic [AW-1:0] tgt, input logic [OW-1:0] ofs,
                        input logic [CW-1:0] cnt, input logic [AW-1:0] lend,
                        input string tag);
        logic [AW-1:0] nx, inc, rel;
        logic lce, at_end, set_o, set_u;
        @(negedge clk);
        pc_i = pc; op_i = op; cond_i = cond; target_i = tgt;
        offset_i = ofs; count_i = cnt; loop_end_i = lend;
        inc = pc + 1'b1;
        rel = pc + {{(AW-OW){ofs[OW-1]}}, ofs};
        lce = (m_csp > 0) && (m_cnt[m_csp-1] <= 1);
        at_end = (m_csp > 0) && (m_psp > 0) && m_ptag[m_psp-1] && (m_paddr[m_psp-1] == pc);
        nx = inc; set_o = 1'b0; set_u = 1'b0;
        if (at_end) begin
            if (lce) begin m_psp--; m_csp--; end
            else begin m_cnt[m_csp-1] = m_cnt[m_csp-1] - 1; nx = m_start[m_csp-1]; end
        end else if (op == 3'd1 && cond) nx = tgt;
        else if (op == 3'd2 && cond) nx = rel;
        else if ((op == 3'd3 || op == 3'd4) && cond) begin
            nx = (op == 3'd3) ? tgt : rel;
            if (m_psp == PD) set_o = 1'b1;
            else begin m_paddr[m_psp] = inc; m_ptag[m_psp] = 1'b0; m_psp++; end
        end else if (op == 3'd5 && cond) begin
            if (m_psp == 0) set_u = 1'b1;
            else begin m_psp--; nx = m_paddr[m_psp]; end
        end else if (op == 3'd6) begin
            if (m_psp == PD || m_csp == LD) set_o = 1'b1;
            else begin
                m_paddr[m_psp] = lend; m_ptag[m_psp] = 1'b1; m_psp++;
                m_cnt[m_csp] = cnt; m_start[m_csp] = inc; m_csp++;
            end
        end
        exp_q.push_back({nx, lce, m_ovf, m_unf});
        tag_q.push_back(tag);
        #2 ->chk_ev;
        m_ovf = m_ovf | set_o;
        m_unf = m_unf | set_u;
        pc = nx;
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 64; i++) begin
            p_op[i] = 3'd0; p_tgt[i] = '0; p_cnt[i] = '0; p_end[i] = '0;
        end
    endtask

    task automatic run_prog(input logic [AW-1:0] start, input logic [AW-1:0] stop,
                            input string tag);
        int n;
        pc = start;
        n = 0;
        while (pc != stop && n < 300) begin
            step(p_op[pc[5:0]], 1'b1, p_tgt[pc[5:0]], '0,
                 p_cnt[pc[5:0]], p_end[pc[5:0]], tag);
            n++;
        end
        n_cmp++;
        if (pc != stop) begin
            n_bad++;
            $display("FAIL %s: actual pc=%h expected stop=%h", tag, pc, stop);
        end
    endtask

    initial begin
        do_reset();
        // R1: reset state
        pc = 24'h5;
        step(3'd0, 1'b0, '0, '0, '0, '0, "R1");
        // R2: jumps, taken and not taken
        step(3'd1, 1'b1, 24'h123456, '0, '0, '0, "R2");
        step(3'd2, 1'b1, '0, 16'hFFFD, '0, '0, "R2");
        step(3'd2, 1'b1, '0, 16'h0100, '0, '0, "R2");
        step(3'd1, 1'b0, 24'h000777, '0, '0, '0, "R2");
        step(3'd2, 1'b0, '0, 16'h0040, '0, '0, "R2");
        // R3: call and return, absolute and relative
        pc = 24'h10;
        step(3'd3, 1'b1, 24'h40, '0, '0, '0, "R3");
        step(3'd0, 1'b1, '0, '0, '0, '0, "R3");
        step(3'd4, 1'b1, '0, 16'h0020, '0, '0, "R3");
        step(3'd5, 1'b0, '0, '0, '0, '0, "R3");
        step(3'd5, 1'b1, '0, '0, '0, '0, "R3");
        step(3'd5, 1'b1, '0, '0, '0, '0, "R3");
        // R10: return on empty stack
        step(3'd5, 1'b1, '0, '0, '0, '0, "R10");
        step(3'd0, 1'b1, '0, '0, '0, '0, "R10");

        // R4/R5: loop of 3 over addresses 1..3
        do_reset();
        clear_prog();
        p_op[0] = 3'd6; p_cnt[0] = 3; p_end[0] = 24'd3;
        run_prog(24'd0, 24'd5, "R4");
        // R6: count 1 and count 0 run once
        clear_prog();
        p_op[0] = 3'd6; p_cnt[0] = 1; p_end[0] = 24'd2;
        p_op[3] = 3'd6; p_cnt[3] = 0; p_end[3] = 24'd4;
        run_prog(24'd0, 24'd6, "R6");
        // R7: nested loops with a call in the inner body
        clear_prog();
        p_op[10] = 3'd6; p_cnt[10] = 2; p_end[10] = 24'd16;
        p_op[11] = 3'd6; p_cnt[11] = 3; p_end[11] = 24'd14;
        p_op[13] = 3'd3; p_tgt[13] = 24'd30;
        p_op[31] = 3'd5;
        run_prog(24'd10, 24'd18, "R7");
        step(3'd5, 1'b1, '0, '0, '0, '0, "R5");

        // R9: counter stack overflow on seventh loop start
        do_reset();
        pc = 24'h100;
        for (int i = 0; i < 7; i++)
            step(3'd6, 1'b1, '0, '0, 32'd5, 24'h800000 + i, "R9");
        step(3'd0, 1'b1, '0, '0, '0, '0, "R9");
        for (int i = 0; i < 7; i++)
            step(3'd5, 1'b1, '0, '0, '0, '0, "R9");

        // R8: return stack overflow on 31st call, then drain
        do_reset();
        pc = 24'h200;
        for (int i = 0; i < 31; i++)
            step(3'd4, 1'b1, '0, 16'h0002, '0, '0, "R8");
        for (int i = 0; i < 31; i++)
            step(3'd5, 1'b1, '0, '0, '0, '0, "R8");
        step(3'd0, 1'b1, '0, '0, '0, '0, "R10");

        @(negedge clk);
        #3;
        summary();
    end
endmodule